// File: doc/BRIEF.md
# Exception entry and return controller

This block keeps the processor-state side of taking an exception, interrupt or trap and of coming back from one. It owns three live status flags (stack mode `sm`, interrupt enable `ie`, carry `c`), a shadow copy of each, and a saved-PC register. Seven event request lines arrive from the pipeline together with strobes that say where the pipeline currently stands: an instruction is executing, an instruction boundary is reached, that boundary is word aligned, or a machine cycle has elapsed.

Each cycle the controller decides which requests may be taken at this point in the pipeline. It then picks one by fixed priority, shadows the live flags and clears them as the event class requires. It records the resume PC that suits the event class and issues a one-cycle redirect to the event's vector. A return strobe copies the shadows back into the live flags and redirects to the saved PC. A status-write port lets the core load the live flags directly.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst_n` is low, every flag, shadow flag, the saved PC, `redirect_o`, `target_o` and `cause_o` are zero.
- R2: A request is taken only at its own point: reset when `mcyc_i` is high; address fault and bad opcode when `exec_i` is high; floating-point fault and trap when `bound_i` is high; system break and external interrupt when both `bound_i` and `wbound_i` are high. At any other time the request changes no state.
- R3: On taking any event the shadow flags receive the live `sm`, `ie` and `c` as they were before that edge, and the live `ie` and `c` become 0.
- R4: The live `sm` keeps its value for address fault, bad opcode, floating-point fault and trap, and becomes 0 for reset, system break and external interrupt.
- R5: The saved PC becomes `cur_pc_i` for address fault and bad opcode, `cur_pc_i + 4` for floating-point fault and trap, and `next_pc_i` for system break and external interrupt. After a reset event its value is unspecified.
- R6: When several requests may be taken in one cycle, the winner is the first in this order: reset, address fault, bad opcode, floating-point fault, trap, system break, external interrupt.
- R7: An external interrupt is not taken while the live `ie` is 0.
- R8: Taking an event raises `redirect_o` for exactly the one cycle after the sampling edge, with `cause_o` = 0 reset, 1 address fault, 2 bad opcode, 3 floating-point fault, 4 trap, 5 system break, 6 external interrupt. `target_o` carries the default vector: 0x00, 0x30, 0x20, 0x50, 0x40, 0x10, 0x80 in that same cause order.
- R9: A return (`rte_i`) in a cycle that takes no event copies the shadow flags into the live flags, raises `redirect_o` for one cycle with `cause_o` = 7 and `target_o` equal to the saved PC. An event taken in the same cycle wins and the return is dropped. After a return the shadows and saved PC are unspecified.
- R10: `psw_wr_i` loads `psw_wdata_i` into the live flags (bit 2 `sm`, bit 1 `ie`, bit 0 `c`) only in a cycle with neither an event nor a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_reset_i | input | 1 | Reset event request |
| ev_addr_i | input | 1 | Address fault request |
| ev_rsvd_i | input | 1 | Bad opcode request |
| ev_fpu_i | input | 1 | Floating-point fault request |
| ev_trap_i | input | 1 | Trap instruction request |
| ev_sbrk_i | input | 1 | System break request |
| ev_ext_i | input | 1 | External interrupt request |
| exec_i | input | 1 | An instruction is in execution |
| bound_i | input | 1 | Instruction boundary reached |
| wbound_i | input | 1 | Current boundary is word aligned |
| mcyc_i | input | 1 | Machine-cycle strobe |
| cur_pc_i | input | AW | PC of the executing or just-completed instruction |
| next_pc_i | input | AW | PC of the next instruction |
| rte_i | input | 1 | Return-from-exception strobe |
| psw_wr_i | input | 1 | Live flag write enable |
| psw_wdata_i | input | 3 | Live flag write data {sm, ie, c} |
| sm_o | output | 1 | Live stack-mode flag |
| ie_o | output | 1 | Live interrupt-enable flag |
| c_o | output | 1 | Live carry flag |
| bsm_o | output | 1 | Shadow stack-mode flag |
| bie_o | output | 1 | Shadow interrupt-enable flag |
| bc_o | output | 1 | Shadow carry flag |
| bpc_o | output | AW | Saved resume PC |
| redirect_o | output | 1 | One-cycle PC redirect strobe |
| target_o | output | AW | Redirect target PC |
| cause_o | output | 3 | Code of the last redirect |

## Verification
Every result of this block is registered once: flags, shadows, saved PC, `redirect_o`, `target_o` and `cause_o` all show the effect of a request at the rising edge that samples it. `redirect_o` falls again at the following edge unless a new event or return is taken. The bench drives stimulus at falling edges, advances its behavioural model at each rising edge from the same inputs, and compares every output 2 ns later. That comparison point is therefore exactly one edge after the stimulus, and the one-cycle redirect pulse is seen both high and then low. Values the requirements leave unspecified are tracked as unknown in the model and skipped.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
    localparam int NEV = 7;
    localparam int CW  = 3;

    // priority index = cause code
    localparam logic [CW-1:0] CAUSE_RESET = 3'd0;
    localparam logic [CW-1:0] CAUSE_ADDR  = 3'd1;
    localparam logic [CW-1:0] CAUSE_RSVD  = 3'd2;
    localparam logic [CW-1:0] CAUSE_FPU   = 3'd3;
    localparam logic [CW-1:0] CAUSE_TRAP  = 3'd4;
    localparam logic [CW-1:0] CAUSE_SBRK  = 3'd5;
    localparam logic [CW-1:0] CAUSE_EXT   = 3'd6;
    localparam logic [CW-1:0] CAUSE_RET   = 3'd7;

    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } flags_t;
endpackage

// File: rtl/exc_elig.sv
`timescale 1ns/1ps
// Qualifies each raw request with the pipeline point at which it may be taken.
module exc_elig
    import exc_pkg::*;
#(
    parameter int N = NEV
) (
    input  logic [N-1:0] req_i,
    input  logic         exec_i,
    input  logic         bound_i,
    input  logic         wbound_i,
    input  logic         mcyc_i,
    input  logic         ie_i,
    output logic [N-1:0] elig_o
);
    for (genvar i = 0; i < N; i++) begin : g_q
        if (i == int'(CAUSE_RESET)) begin : g_rst
            assign elig_o[i] = req_i[i] & mcyc_i;
        end else if (i == int'(CAUSE_ADDR) || i == int'(CAUSE_RSVD)) begin : g_cancel
            assign elig_o[i] = req_i[i] & exec_i;
        end else if (i == int'(CAUSE_FPU) || i == int'(CAUSE_TRAP)) begin : g_done
            assign elig_o[i] = req_i[i] & bound_i;
        end else if (i == int'(CAUSE_SBRK)) begin : g_sbrk
            assign elig_o[i] = req_i[i] & bound_i & wbound_i;
        end else begin : g_ext
            assign elig_o[i] = req_i[i] & bound_i & wbound_i & ie_i;
        end
    end
endmodule

// File: rtl/exc_prio.sv
`timescale 1ns/1ps
// Fixed-priority pick: lowest index wins.
module exc_prio
    import exc_pkg::*;
#(
    parameter int N  = NEV,
    parameter int IW = CW
) (
    input  logic [N-1:0]  elig_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |elig_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/exc_route.sv
`timescale 1ns/1ps
// Per-event vector, resume PC and stack-mode policy.
module exc_route
    import exc_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int unsigned STEP      = 4,
    parameter int unsigned VEC_RESET = 'h00,
    parameter int unsigned VEC_ADDR  = 'h30,
    parameter int unsigned VEC_RSVD  = 'h20,
    parameter int unsigned VEC_FPU   = 'h50,
    parameter int unsigned VEC_TRAP  = 'h40,
    parameter int unsigned VEC_SBRK  = 'h10,
    parameter int unsigned VEC_EXT   = 'h80
) (
    input  logic [CW-1:0] idx_i,
    input  logic [AW-1:0] cur_pc_i,
    input  logic [AW-1:0] next_pc_i,
    output logic [AW-1:0] vec_o,
    output logic [AW-1:0] bpc_o,
    output logic          bpc_wr_o,
    output logic          sm_clr_o
);
    logic [AW-1:0] pc_step;
    assign pc_step = cur_pc_i + AW'(STEP);

    always_comb begin
        vec_o    = AW'(VEC_EXT);
        bpc_o    = next_pc_i;
        bpc_wr_o = 1'b1;
        sm_clr_o = 1'b0;
        case (idx_i)
            CAUSE_RESET: begin
                vec_o    = AW'(VEC_RESET);
                bpc_wr_o = 1'b0;
                sm_clr_o = 1'b1;
            end
            CAUSE_ADDR: begin
                vec_o = AW'(VEC_ADDR);
                bpc_o = cur_pc_i;
            end
            CAUSE_RSVD: begin
                vec_o = AW'(VEC_RSVD);
                bpc_o = cur_pc_i;
            end
            CAUSE_FPU: begin
                vec_o = AW'(VEC_FPU);
                bpc_o = pc_step;
            end
            CAUSE_TRAP: begin
                vec_o = AW'(VEC_TRAP);
                bpc_o = pc_step;
            end
            CAUSE_SBRK: begin
                vec_o    = AW'(VEC_SBRK);
                sm_clr_o = 1'b1;
            end
            default: begin
                vec_o    = AW'(VEC_EXT);
                sm_clr_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/exc_ctrl.sv
`timescale 1ns/1ps
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int unsigned STEP      = 4,
    parameter int unsigned VEC_RESET = 'h00,
    parameter int unsigned VEC_ADDR  = 'h30,
    parameter int unsigned VEC_RSVD  = 'h20,
    parameter int unsigned VEC_FPU   = 'h50,
    parameter int unsigned VEC_TRAP  = 'h40,
    parameter int unsigned VEC_SBRK  = 'h10,
    parameter int unsigned VEC_EXT   = 'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_reset_i,
    input  logic          ev_addr_i,
    input  logic          ev_rsvd_i,
    input  logic          ev_fpu_i,
    input  logic          ev_trap_i,
    input  logic          ev_sbrk_i,
    input  logic          ev_ext_i,
    input  logic          exec_i,
    input  logic          bound_i,
    input  logic          wbound_i,
    input  logic          mcyc_i,
    input  logic [AW-1:0] cur_pc_i,
    input  logic [AW-1:0] next_pc_i,
    input  logic          rte_i,
    input  logic          psw_wr_i,
    input  logic [2:0]    psw_wdata_i,
    output logic          sm_o,
    output logic          ie_o,
    output logic          c_o,
    output logic          bsm_o,
    output logic          bie_o,
    output logic          bc_o,
    output logic [AW-1:0] bpc_o,
    output logic          redirect_o,
    output logic [AW-1:0] target_o,
    output logic [CW-1:0] cause_o
);
    typedef struct packed {
        flags_t        fl;
        flags_t        bk;
        logic [AW-1:0] bpc;
        logic          redir;
        logic [AW-1:0] tgt;
        logic [CW-1:0] cause;
    } st_t;

    st_t st_d, st_q;

    logic [NEV-1:0] req, elig;
    logic           take;
    logic [CW-1:0]  idx;
    logic [AW-1:0]  vec, bpc_new;
    logic           bpc_wr, sm_clr;

    assign req = {ev_ext_i, ev_sbrk_i, ev_trap_i, ev_fpu_i,
                  ev_rsvd_i, ev_addr_i, ev_reset_i};

    exc_elig #(.N(NEV)) u_elig (
        .req_i    (req),
        .exec_i   (exec_i),
        .bound_i  (bound_i),
        .wbound_i (wbound_i),
        .mcyc_i   (mcyc_i),
        .ie_i     (st_q.fl.ie),
        .elig_o   (elig)
    );

    exc_prio #(.N(NEV), .IW(CW)) u_prio (
        .elig_i (elig),
        .any_o  (take),
        .idx_o  (idx)
    );

    exc_route #(
        .AW(AW), .STEP(STEP),
        .VEC_RESET(VEC_RESET), .VEC_ADDR(VEC_ADDR), .VEC_RSVD(VEC_RSVD),
        .VEC_FPU(VEC_FPU), .VEC_TRAP(VEC_TRAP), .VEC_SBRK(VEC_SBRK),
        .VEC_EXT(VEC_EXT)
    ) u_route (
        .idx_i     (idx),
        .cur_pc_i  (cur_pc_i),
        .next_pc_i (next_pc_i),
        .vec_o     (vec),
        .bpc_o     (bpc_new),
        .bpc_wr_o  (bpc_wr),
        .sm_clr_o  (sm_clr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        if (take) begin
            st_d.bk    = st_q.fl;
            st_d.fl.ie = 1'b0;
            st_d.fl.c  = 1'b0;
            if (sm_clr) st_d.fl.sm = 1'b0;
            if (bpc_wr) st_d.bpc = bpc_new;
            st_d.redir = 1'b1;
            st_d.tgt   = vec;
            st_d.cause = idx;
        end else if (rte_i) begin
            st_d.fl    = st_q.bk;
            st_d.redir = 1'b1;
            st_d.tgt   = st_q.bpc;
            st_d.cause = CAUSE_RET;
        end else if (psw_wr_i) begin
            st_d.fl = flags_t'(psw_wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sm_o       = st_q.fl.sm;
    assign ie_o       = st_q.fl.ie;
    assign c_o        = st_q.fl.c;
    assign bsm_o      = st_q.bk.sm;
    assign bie_o      = st_q.bk.ie;
    assign bc_o       = st_q.bk.c;
    assign bpc_o      = st_q.bpc;
    assign redirect_o = st_q.redir;
    assign target_o   = st_q.tgt;
    assign cause_o    = st_q.cause;
endmodule

// File: rtl/exc_ctrl_chk.sv
`timescale 1ns/1ps
module exc_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sm_o,
    input logic          ie_o,
    input logic          c_o,
    input logic          bsm_o,
    input logic          bie_o,
    input logic          bc_o,
    input logic [AW-1:0] bpc_o,
    input logic          redirect_o,
    input logic [2:0]    cause_o
);
    logic is_evt;
    assign is_evt = redirect_o && (cause_o != 3'd7);

    p_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_evt |-> (bsm_o == $past(sm_o)) && (bie_o == $past(ie_o)) && (bc_o == $past(c_o)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_evt |-> !ie_o && !c_o);

    p_smclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_evt && (cause_o == 3'd0 || cause_o == 3'd5 || cause_o == 3'd6) |-> !sm_o);

    p_smkeep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_evt && (cause_o >= 3'd1) && (cause_o <= 3'd4) |-> sm_o == $past(sm_o));

    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o && (cause_o == 3'd6) |-> $past(ie_o));

    p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o && (cause_o == 3'd7) |->
            (sm_o == $past(bsm_o)) && (ie_o == $past(bie_o)) && (c_o == $past(bc_o))
            && $stable(bpc_o));
endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sm_o       (sm_o),
    .ie_o       (ie_o),
    .c_o        (c_o),
    .bsm_o      (bsm_o),
    .bie_o      (bie_o),
    .bc_o       (bc_o),
    .bpc_o      (bpc_o),
    .redirect_o (redirect_o),
    .cause_o    (cause_o)
);

// File: tb/sim_exc_ctrl.sv
`timescale 1ns/1ps
module sim_exc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev = '0;   // 0 reset,1 addr,2 rsvd,3 fpu,4 trap,5 sbrk,6 ext
    logic        exec_s = 0, bound_s = 0, wb_s = 0, mc_s = 0, rte_s = 0, pw_s = 0;
    logic [2:0]  pd_s = '0;
    logic [31:0] cur_pc = '0, next_pc = '0;
    logic        sm, ie, c, bsm, bie, bc, redir;
    logic [31:0] bpc, tgt;
    logic [2:0]  cause;

    always #10 clk = ~clk;

    exc_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_reset_i(ev[0]), .ev_addr_i(ev[1]), .ev_rsvd_i(ev[2]), .ev_fpu_i(ev[3]),
        .ev_trap_i(ev[4]), .ev_sbrk_i(ev[5]), .ev_ext_i(ev[6]),
        .exec_i(exec_s), .bound_i(bound_s), .wbound_i(wb_s), .mcyc_i(mc_s),
        .cur_pc_i(cur_pc), .next_pc_i(next_pc), .rte_i(rte_s),
        .psw_wr_i(pw_s), .psw_wdata_i(pd_s),
        .sm_o(sm), .ie_o(ie), .c_o(c), .bsm_o(bsm), .bie_o(bie), .bc_o(bc),
        .bpc_o(bpc), .redirect_o(redir), .target_o(tgt), .cause_o(cause)
    );

    int    checks = 0, fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_sm, m_ie, m_c, m_bsm, m_bie, m_bc, m_redir;
    bit          bk_known, bpc_known;
    logic [31:0] m_bpc, m_tgt;
    int          m_cause;

    function automatic logic [31:0] vector_of(int k);
        case (k)
            0: return 32'h00; 1: return 32'h30; 2: return 32'h20; 3: return 32'h50;
            4: return 32'h40; 5: return 32'h10; default: return 32'h80;
        endcase
    endfunction

    task automatic accept(int k);
        m_bsm = m_sm; m_bie = m_ie; m_bc = m_c;
        m_ie = 0; m_c = 0;
        if (k == 0 || k == 5 || k == 6) m_sm = 0;
        if (k == 0) bpc_known = 0;
        else if (k <= 2) begin m_bpc = cur_pc; bpc_known = 1; end
        else if (k <= 4) begin m_bpc = cur_pc + 32'd4; bpc_known = 1; end
        else begin m_bpc = next_pc; bpc_known = 1; end
        bk_known = 1;
        m_redir = 1; m_tgt = vector_of(k); m_cause = k;
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_sm, m_ie, m_c, m_bsm, m_bie, m_bc, m_redir} = '0;
            m_bpc = '0; m_tgt = '0; m_cause = 0; bk_known = 1; bpc_known = 1;
        end else begin
            m_redir = 0;
            if (ev[0] && mc_s) accept(0);
            else if (ev[1] && exec_s) accept(1);
            else if (ev[2] && exec_s) accept(2);
            else if (ev[3] && bound_s) accept(3);
            else if (ev[4] && bound_s) accept(4);
            else if (ev[5] && bound_s && wb_s) accept(5);
            else if (ev[6] && bound_s && wb_s && m_ie) accept(6);
            else if (rte_s) begin
                m_sm = m_bsm; m_ie = m_bie; m_c = m_bc;
                m_redir = 1; m_tgt = m_bpc; m_cause = 7;
                bk_known = 0; bpc_known = 0;
            end else if (pw_s) begin
                m_sm = pd_s[2]; m_ie = pd_s[1]; m_c = pd_s[0];
            end
        end
        #2;
        chk("sm", 32'(sm), 32'(m_sm));
        chk("ie", 32'(ie), 32'(m_ie));
        chk("c", 32'(c), 32'(m_c));
        chk("redirect", 32'(redir), 32'(m_redir));
        if (m_redir) begin
            chk("target", tgt, m_tgt);
            chk("cause", 32'(cause), 32'(m_cause));
        end
        if (bk_known) begin
            chk("bsm", 32'(bsm), 32'(m_bsm));
            chk("bie", 32'(bie), 32'(m_bie));
            chk("bc", 32'(bc), 32'(m_bc));
        end
        if (bpc_known) chk("bpc", bpc, m_bpc);
    end

    // one stimulus cycle; strobes {exec,bound,wbound,mcyc}
    task automatic cyc(string r, logic [6:0] e, logic [3:0] st, logic rt = 0,
                       logic pw = 0, logic [2:0] pd = 3'b000);
        @(negedge clk);
        cur_req = r;
        ev = e; {exec_s, bound_s, wb_s, mc_s} = st;
        rte_s = rt; pw_s = pw; pd_s = pd;
    endtask

    task automatic idle(string r);
        cyc(r, 7'b0, 4'b0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle("R1");
        // R10: status write, then ignored when an event takes the cycle
        cyc("R10", 7'b0, 4'b0000, 0, 1, 3'b111);
        idle("R10");
        cur_pc = 32'h1000; next_pc = 32'h1004;
        cyc("R10", 7'b0010000, 4'b0100, 0, 1, 3'b000);  // trap wins over write
        idle("R8");
        cyc("R9", 7'b0, 4'b0000, 1);                    // return to 0x1004
        idle("R9");
        // R2: trap away from a boundary is ignored
        cyc("R2", 7'b0010000, 4'b1000);
        idle("R2");
        // R2: external at a boundary that is not word aligned
        cyc("R2", 7'b1000000, 4'b0100);
        idle("R2");
        next_pc = 32'h2222;
        cyc("R5", 7'b1000000, 4'b0110);                 // taken, bpc = next_pc
        idle("R4");
        cyc("R9", 7'b0, 4'b0000, 1);
        idle("R9");
        // R7: masked external
        cyc("R7", 7'b0, 4'b0000, 0, 1, 3'b101);
        cyc("R7", 7'b1000000, 4'b0110);
        idle("R7");
        // R2/R5: address fault needs exec
        cur_pc = 32'h3000;
        cyc("R2", 7'b0000010, 4'b0110);
        cyc("R5", 7'b0000010, 4'b1000);
        idle("R3");
        cyc("R9", 7'b0, 4'b0000, 1);
        cur_pc = 32'h3100;
        cyc("R5", 7'b0000100, 4'b1000);                 // bad opcode
        idle("R4");
        cur_pc = 32'h3200;
        cyc("R5", 7'b0001000, 4'b0100);                 // fp fault, +4
        idle("R4");
        cyc("R2", 7'b0000001, 4'b1110);                 // reset without mcyc
        cyc("R4", 7'b0000001, 4'b0001);                 // reset taken
        idle("R1");
        // R6: priority ladder
        for (int k = 0; k < 7; k++) begin
            cyc("R6", 7'b0, 4'b0000, 0, 1, 3'b111);
            cur_pc = 32'h4000 + 32'(k * 16); next_pc = cur_pc + 32'd2;
            cyc("R6", 7'h7f << k, 4'b1111);
            idle("R6");
        end
        // R9: return and event in one cycle: event wins
        cyc("R9", 7'b0010000, 4'b0100, 1);
        idle("R9");
        cyc("R9", 7'b0, 4'b0000, 1);
        idle("R8");
        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            logic [6:0] e;
            e = 7'($urandom) & 7'b1111110;
            e[0] = ($urandom % 20) == 0;
            cur_pc = $urandom & 32'hffff_fffc;
            next_pc = $urandom & 32'hffff_fffe;
            cyc("R6", e, 4'($urandom), (($urandom % 3) == 0) && bk_known && bpc_known,
                ($urandom % 4) == 0, 3'($urandom));
        end
        idle("R8");
        idle("R8");
        finish_run();
    end
endmodule